// File: doc/BRIEF.md
# Quadrature Position Counter with Index Clear

This block tracks the position of a rotary or linear encoder. Two phase inputs, A and B, are 90 degrees apart, and every edge on either one moves a 16-bit counter by one step. The direction of the step follows which phase leads. The counter runs free: it wraps from the top of its range to zero and from zero to the top, and each wrap raises a one-cycle interrupt request. A third input marks the encoder's reference position. Once software arms it, the chosen edge on that input returns the count to zero.

All sampling is paced by a count-source enable, `tick`. The block does nothing on clock cycles where `tick` is low. Software loads the counter through a write strobe with a value. It programs three control bits through a second strobe: index enable, index edge polarity, and a mode bit that confirms the counter is free-running with four-times decoding. The index clear works only after a zero has been loaded and all three conditions hold.

Top module: `qdc_index_counter`

## Requirements
- R1: After reset the count is 0000h and `irq` and `err` are 0.
- R2: A load write (`ld_we`=1) sets the count to `ld_val` in the next cycle, has priority over counting and clearing, and clears `err`.
- R3: Phase levels form a 2-bit state {A,B}. When exactly one phase changes, the count moves by one: up when new A XOR previous B is 1 (A leads, order 00,10,11,01), down otherwise. The step lands on the third tick after the input change.
- R4: If A and B both change within one sample, the count is unchanged and the sticky `err` flag sets. Only a load clears it.
- R5: An up step from FFFFh gives 0000h and a down step from 0000h gives FFFFh. Each wrap drives `irq` high for exactly one cycle, the cycle after the tick.
- R6: The index clear is armed only while the last load value was 0000h, `cfg_idx_en`=1 and `cfg_x4_free`=1. Otherwise the index input has no effect on the count.
- R7: `cfg_idx_rise`=1 selects the rising edge of the index input and 0 selects the falling edge. The opposite edge has no effect.
- R8: An index edge is seen on the third tick after it arrives. The count becomes zero on the following tick, not sooner. An edge seen on the consuming tick is absorbed into the pending clear.
- R9: If the tick that applies an index clear also carries a step that would wrap, the count becomes 0000h and `irq` is high for two consecutive cycles.
- R10: With `tick` low and no load, the count stays unchanged whatever the phase inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Count-source enable, one cycle per sample |
| phase_a | input | 1 | Encoder phase A |
| phase_b | input | 1 | Encoder phase B |
| index_in | input | 1 | Encoder reference (index) input |
| ld_we | input | 1 | Counter load strobe |
| ld_val | input | 16 | Counter load value |
| cfg_we | input | 1 | Control write strobe |
| cfg_idx_en | input | 1 | Index clear enable |
| cfg_idx_rise | input | 1 | Index polarity, 1 = rising edge |
| cfg_x4_free | input | 1 | Free-running four-times decoding confirmed |
| count | output | 16 | Current count |
| irq | output | 1 | Wrap interrupt request pulse |
| err | output | 1 | Sticky illegal-transition flag |

## Verification
The assertions check on every cycle that the count holds between ticks, moves by at most one per tick, and goes to zero after a clear fires. They also check that a pending clear never outlives its tick, that `err` stays set until a load, and that `irq` only follows a tick. The bench's scenarios are needed for the rest. They sweep all sixteen phase transitions to confirm direction and the illegal case, show the three-tick latency, exercise each arming condition and each polarity, and build the wrap-plus-clear collision that doubles the interrupt.

// File: rtl/qdc_pkg.sv
// Shared types for the quadrature counter.
package qdc_pkg;
    // Result of comparing the present phase state with the last one.
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2,
        STEP_BAD  = 2'd3
    } step_t;
endpackage

// File: rtl/qdc_sync.sv
// Tick-paced input conditioning: two synchronizer flops per line plus a
// "last" flop, so edge logic can compare now against last.
// Assumes all lines may be asynchronous to clk; stages advance only on tick.
module qdc_sync #(
    parameter int NLINES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [NLINES-1:0] raw,
    output logic [NLINES-1:0] now,
    output logic [NLINES-1:0] last
);
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        logic s1, s2, sl;
        // Shift the line through its three stages on each tick.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
                sl <= 1'b0;
            end else if (tick) begin
                s1 <= raw[i];
                s2 <= s1;
                sl <= s2;
            end
        end
        assign now[i]  = s2;
        assign last[i] = sl;
    end
endmodule

// File: rtl/qdc_decode.sv
// Four-times quadrature decoder: classifies a change of the {A,B} state
// as one step up, one step down, none, or an illegal double change.
// Assumes now/last come from the tick-paced synchronizer.
module qdc_decode
    import qdc_pkg::*;
(
    input  logic  a_now,
    input  logic  b_now,
    input  logic  a_last,
    input  logic  b_last,
    output step_t step
);
    logic a_chg, b_chg;
    assign a_chg = a_now ^ a_last;
    assign b_chg = b_now ^ b_last;

    // Pick the step from which phases moved and the phase relation.
    always_comb begin
        if (a_chg && b_chg)
            step = STEP_BAD;
        else if (a_chg || b_chg)
            step = (a_now ^ b_last) ? STEP_UP : STEP_DOWN;
        else
            step = STEP_NONE;
    end
endmodule

// File: rtl/qdc_index.sv
// Index clear control: holds the control bits, tracks whether a zero was
// loaded, detects the selected index edge and keeps a clear pending until
// the next tick consumes it. Assumes z_now/z_last are tick-paced.
module qdc_index (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic z_now,
    input  logic z_last,
    input  logic ld_we,
    input  logic ld_zero,
    input  logic cfg_we,
    input  logic cfg_idx_en,
    input  logic cfg_idx_rise,
    input  logic cfg_x4_free,
    output logic clear_fire
);
    logic en_q, rise_q, x4_q, zero_q, pend_q, armed, z_edge;

    // Capture control bits on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            rise_q <= 1'b0;
            x4_q   <= 1'b0;
        end else if (cfg_we) begin
            en_q   <= cfg_idx_en;
            rise_q <= cfg_idx_rise;
            x4_q   <= cfg_x4_free;
        end
    end

    // Remember whether the most recent load value was zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            zero_q <= 1'b0;
        else if (ld_we)
            zero_q <= ld_zero;
    end

    assign armed  = en_q && x4_q && zero_q;
    assign z_edge = rise_q ? (z_now && !z_last) : (!z_now && z_last);

    // Hold a detected edge until the following tick uses it.
    always_ff @(posedge clk) begin
        if (!rst_n || !armed)
            pend_q <= 1'b0;
        else if (tick)
            pend_q <= pend_q ? 1'b0 : z_edge;
    end

    assign clear_fire = pend_q && tick;

    // R8: a pending clear is always gone after the tick that consumes it.
    assert_pending_consumed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && tick) |=> !pend_q);
    // R6: nothing stays pending while the clear is disarmed.
    assert_disarmed_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !cfg_we && !ld_we) |=> !pend_q);
endmodule

// File: rtl/qdc_index_counter.sv
// Free-running 16-bit quadrature position counter with index clear and
// wrap interrupt. Assumes tick is a single-cycle count-source enable.
module qdc_index_counter
    import qdc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             phase_a,
    input  logic             phase_b,
    input  logic             index_in,
    input  logic             ld_we,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             cfg_we,
    input  logic             cfg_idx_en,
    input  logic             cfg_idx_rise,
    input  logic             cfg_x4_free,
    output logic [CNT_W-1:0] count,
    output logic             irq,
    output logic             err
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [2:0] ln_now, ln_last;
    step_t      step;
    logic       clear_fire, wrap_now, wrap_evt, irq_again;

    qdc_sync #(.NLINES(3)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .raw  ({index_in, phase_b, phase_a}),
        .now  (ln_now),
        .last (ln_last)
    );

    qdc_decode u_dec (
        .a_now (ln_now[0]),
        .b_now (ln_now[1]),
        .a_last(ln_last[0]),
        .b_last(ln_last[1]),
        .step  (step)
    );

    qdc_index u_idx (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .z_now       (ln_now[2]),
        .z_last      (ln_last[2]),
        .ld_we       (ld_we),
        .ld_zero     (ld_val == '0),
        .cfg_we      (cfg_we),
        .cfg_idx_en  (cfg_idx_en),
        .cfg_idx_rise(cfg_idx_rise),
        .cfg_x4_free (cfg_x4_free),
        .clear_fire  (clear_fire)
    );

    assign wrap_now = (step == STEP_UP && count == CNT_MAX) ||
                      (step == STEP_DOWN && count == '0);
    assign wrap_evt = tick && !ld_we && wrap_now;

    // Update the count: load first, then index clear, then a step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (ld_we)
            count <= ld_val;
        else if (tick) begin
            if (clear_fire)
                count <= '0;
            else if (step == STEP_UP)
                count <= count + CNT_ONE;
            else if (step == STEP_DOWN)
                count <= count - CNT_ONE;
        end
    end

    // Keep the illegal-transition flag until software loads the counter.
    always_ff @(posedge clk) begin
        if (!rst_n || ld_we)
            err <= 1'b0;
        else if (tick && step == STEP_BAD)
            err <= 1'b1;
    end

    // Pulse irq on a wrap; repeat it once when a clear coincides.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq       <= 1'b0;
            irq_again <= 1'b0;
        end else begin
            irq       <= wrap_evt || irq_again;
            irq_again <= wrap_evt && clear_fire;
        end
    end

    // R10: the count holds on cycles with no tick and no load.
    assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ld_we) |=> $stable(count));
    // R3: a tick moves the count by at most one.
    assert_step_by_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_we && !clear_fire) |=>
            (count == $past(count) || count == $past(count) + CNT_ONE ||
             count == $past(count) - CNT_ONE));
    // R8: a fired clear leaves zero in the counter.
    assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_fire && !ld_we) |=> (count == '0));
    // R4: err is sticky until a load.
    assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !ld_we) |=> err);
    // R5: an interrupt request only follows a tick by one or two cycles.
    assert_irq_after_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(tick) || $past(tick, 2)));
endmodule

// File: tb/qdc_index_counter_test.sv
module qdc_index_counter_test;
    logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
    logic        phase_a = 1'b0, phase_b = 1'b0, index_in = 1'b0;
    logic        ld_we = 1'b0, cfg_we = 1'b0;
    logic        cfg_idx_en = 1'b0, cfg_idx_rise = 1'b0, cfg_x4_free = 1'b0;
    logic [15:0] ld_val = '0;
    logic [15:0] count;
    logic        irq, err;
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    qdc_index_counter uut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .phase_a(phase_a), .phase_b(phase_b), .index_in(index_in),
        .ld_we(ld_we), .ld_val(ld_val), .cfg_we(cfg_we),
        .cfg_idx_en(cfg_idx_en), .cfg_idx_rise(cfg_idx_rise),
        .cfg_x4_free(cfg_x4_free),
        .count(count), .irq(irq), .err(err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic one_tick();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) one_tick();
    endtask

    task automatic load(input logic [15:0] v);
        @(negedge clk) begin ld_we = 1'b1; ld_val = v; end
        @(negedge clk) ld_we = 1'b0;
    endtask

    task automatic cfg(input logic en, input logic rise, input logic x4);
        @(negedge clk) begin
            cfg_we = 1'b1; cfg_idx_en = en; cfg_idx_rise = rise; cfg_x4_free = x4;
        end
        @(negedge clk) cfg_we = 1'b0;
    endtask

    // Move the phases to state {a,b} and let three ticks carry it through.
    task automatic move(input logic [1:0] ab);
        @(negedge clk) begin phase_a = ab[1]; phase_b = ab[0]; end
        ticks(3);
    endtask

    task automatic set_z(input logic z);
        @(negedge clk) index_in = z;
        ticks(4);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 count", count, 0);
        chk("R1 irq", irq, 0);
        chk("R1 err", err, 0);

        load(16'h1234);
        chk("R2 load", count, 16'h1234);

        // No tick: the count must hold while phase A moves.
        @(negedge clk) phase_a = 1'b1;
        repeat (6) @(negedge clk);
        chk("R10 hold", count, 16'h1234);
        ticks(2);
        chk("R3 not yet after two ticks", count, 16'h1234);
        one_tick();
        chk("R3 third tick", count, 16'h1235);
        move(2'b00);
        chk("R3 back down", count, 16'h1234);

        // All sixteen transitions between phase states.
        for (int p = 0; p < 4; p++) begin
            for (int n = 0; n < 4; n++) begin
                logic [1:0] pv, nv;
                int exp_d;
                logic exp_e;
                pv = 2'(p); nv = 2'(n);
                move(pv);
                load(16'h1000);
                chk("R4 err cleared by load", err, 0);
                move(nv);
                exp_e = (pv[1] != nv[1]) && (pv[0] != nv[0]);
                if (pv == nv || exp_e) exp_d = 0;
                else exp_d = (nv[1] ^ pv[0]) ? 1 : -1;
                chk(exp_e ? "R4 illegal count" : "R3 step", count, 32'(16'(16'h1000 + exp_d)));
                chk("R4 err flag", err, 32'(exp_e));
            end
        end
        load(16'h0000);
        chk("R4 err cleared", err, 0);

        // Two full up cycles then two down cycles from state 00.
        move(2'b00);
        load(16'h0010);
        for (int k = 0; k < 2; k++) begin
            move(2'b10); move(2'b11); move(2'b01); move(2'b00);
        end
        chk("R3 up walk", count, 16'h0018);
        for (int k = 0; k < 2; k++) begin
            move(2'b01); move(2'b11); move(2'b10); move(2'b00);
        end
        chk("R3 down walk", count, 16'h0010);

        // Wraps in both directions.
        load(16'hFFFF);
        move(2'b10);
        chk("R5 up wrap value", count, 16'h0000);
        chk("R5 up wrap irq", irq, 1);
        @(negedge clk);
        chk("R5 irq one cycle", irq, 0);
        load(16'h0000);
        move(2'b00);
        chk("R5 down wrap value", count, 16'hFFFF);
        chk("R5 down wrap irq", irq, 1);
        @(negedge clk);
        chk("R5 irq one cycle", irq, 0);

        // Index: enabled but last load nonzero.
        load(16'h0005);
        cfg(1'b1, 1'b1, 1'b1);
        set_z(1'b1);
        chk("R6 no zero load", count, 16'h0005);
        set_z(1'b0);

        // Index: zero loaded but mode bit off.
        load(16'h0000);
        move(2'b10); move(2'b11);
        chk("R3 pre index", count, 16'h0002);
        cfg(1'b1, 1'b1, 1'b0);
        set_z(1'b1);
        chk("R6 mode off", count, 16'h0002);
        set_z(1'b0);

        // Fully armed, rising edge; check clear timing.
        cfg(1'b1, 1'b1, 1'b1);
        @(negedge clk) index_in = 1'b1;
        ticks(3);
        chk("R8 not before next tick", count, 16'h0002);
        one_tick();
        chk("R8 clear on next tick", count, 16'h0000);
        chk("R7 rising clears", count, 16'h0000);
        move(2'b01);
        chk("R3 after clear", count, 16'h0001);
        set_z(1'b0);
        chk("R7 falling ignored", count, 16'h0001);

        // Falling polarity.
        cfg(1'b1, 1'b0, 1'b1);
        set_z(1'b1);
        chk("R7 rising ignored", count, 16'h0001);
        set_z(1'b0);
        chk("R7 falling clears", count, 16'h0000);

        // Collision: clear tick also carries a down step from zero.
        cfg(1'b1, 1'b1, 1'b1);
        @(negedge clk) index_in = 1'b1;
        one_tick();
        @(negedge clk) begin phase_a = 1'b1; phase_b = 1'b1; end
        ticks(3);
        chk("R9 count zero", count, 16'h0000);
        chk("R9 first irq", irq, 1);
        @(negedge clk);
        chk("R9 second irq", irq, 1);
        @(negedge clk);
        chk("R9 irq ends", irq, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule